// File: doc/BRIEF.md
# Smart Card Session Activation Sequencer

This block is the control state machine that brings a smart card session up and takes it down again. It watches card presence, an active-low session command, a supply-good flag from the card regulator and a reset-input pin from the host. It drives the card supply enable, the enable of the I/O level shifters, the card clock gate, the card reset level and a one-cycle interrupt pulse. All delays are counted in system clock cycles and set by parameters. All inputs are taken to be synchronous to `clk`.

Two activation modes exist. The mode is latched from the reset-input pin when a session starts. In timed mode, the clock and then the reset stage follow the I/O enable after fixed cycle delays. In reset-gated mode, the host starts the card clock with a falling edge on the reset-input pin. The card reset output is held low until a long window has run out, and after that it copies the pin. If any stop condition appears, the block removes the card signals in reverse order, one per cycle, and returns to standby.

Top module: `card_act_seq`

## Requirements
- R1: After reset all outputs (`supply_en`, `io_en`, `clk_en`, `card_rst`, `irq`) are low and the block waits in standby.
- R2: In standby a session starts when `sess_cmd_n` is low and `card_present` is high, and `supply_en` rises on the next cycle. A low `sess_cmd_n` with no card present has no effect.
- R3: While the supply ramps, `io_en`, `clk_en` and `card_rst` stay low. The sequence waits, without a time limit, until `supply_good` is sampled high. `io_en` rises on the cycle after that sample.
- R4: In timed mode `clk_en` rises `IO2CLK_CYC` cycles after `io_en`. The reset stage opens `CLK2RST_CYC` cycles after `clk_en`.
- R5: The mode is latched from `rst_in` at session start: high selects reset-gated mode, low selects timed mode. Later changes of `rst_in` do not change the mode of the current session.
- R6: In reset-gated mode `clk_en` rises on the cycle after the first high-to-low transition of `rst_in` that is sampled while `io_en` is high.
- R7: In reset-gated mode `card_rst` stays low until `WIN_CYC` cycles after `io_en` rose. From then on it copies `rst_in`, and `rst_in` no longer affects `clk_en`.
- R8: In reset-gated mode, if `rst_in` has not fallen when the window ends, `clk_en` rises at the window end (`WIN_CYC` cycles after `io_en`). The reset stage opens one cycle later.
- R9: In timed mode, once the reset stage is open, `card_rst` equals `rst_in`.
- R10: Deactivation starts when `sess_cmd_n` goes high or `card_present` goes low, or when `supply_good` goes low after the I/O stage. `card_rst` drops on the next cycle, then `clk_en`, `io_en` and `supply_en` drop one cycle apart in that order, and standby is re-entered together with the supply drop.
- R11: `irq` pulses high for one cycle, one cycle after any change of `card_present` and one cycle after a deactivation caused by card removal or supply loss. A deactivation caused by raising `sess_cmd_n` produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present | input | 1 | High while a card is inserted |
| sess_cmd_n | input | 1 | Session command, low requests an active session |
| supply_good | input | 1 | Card supply has reached its programmed level |
| rst_in | input | 1 | Host reset-input pin, selects the mode and drives card reset |
| supply_en | output | 1 | Card supply regulator enable |
| io_en | output | 1 | Enable for the I/O and auxiliary level shifters |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset level |
| irq | output | 1 | One-cycle status interrupt pulse |

## Verification
The bench builds the block with `IO2CLK_CYC`=4, `CLK2RST_CYC`=3 and `WIN_CYC`=20. With these values a whole timed activation fits in under ten cycles, and a reset-gated window in twenty. This lets the bench drop `rst_in` well inside the window, hold it past expiry for the fallback clock start, and toggle it after expiry, all within a short run. The default window of 50,000,000 cycles (200 ms at 250 MHz) only changes the counter width. It adds no separate behaviour.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_IO,
    ST_CLKW,
    ST_WIN,
    ST_ON,
    ST_DOWN
  } seq_st_e;

  // Any stop condition; supply loss only counts once the supply is trusted.
  function automatic logic abort_req(input logic cmd_n, input logic pres,
                                     input logic good, input logic chk_good);
    return cmd_n | ~pres | (chk_good & ~good);
  endfunction

  // Stop conditions that are faults rather than a host request.
  function automatic logic fault_req(input logic pres, input logic good,
                                     input logic chk_good);
    return ~pres | (chk_good & ~good);
  endfunction

  // Last cycle of a delay of lim cycles counted from zero.
  function automatic logic limit_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim - 1;
  endfunction

endpackage

// File: rtl/card_act_timer.sv
module card_act_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/card_act_evt.sv
module card_act_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_in,
  input  logic card_present,
  output logic rin_fall,
  output logic pres_chg
);
  logic rin_q;
  logic pres_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rin_q  <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      rin_q  <= rst_in;
      pres_q <= card_present;
    end
  end

  assign rin_fall = rin_q & ~rst_in;
  assign pres_chg = pres_q ^ card_present;
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import card_act_pkg::*;
#(
  parameter int IO2CLK_CYC  = 125,
  parameter int CLK2RST_CYC = 125,
  parameter int WIN_CYC     = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_present,
  input  logic sess_cmd_n,
  input  logic supply_good,
  input  logic rst_in,
  output logic supply_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic irq
);
  localparam int MAXA = (IO2CLK_CYC > CLK2RST_CYC) ? IO2CLK_CYC : CLK2RST_CYC;
  localparam int MAXC = (MAXA > WIN_CYC) ? MAXA : WIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_e       state;
  logic          sup_q, io_q, clk_q, rs_q, cbr_q, irq_q;
  logic [1:0]    step_q;
  logic [CW-1:0] cnt;

  // named internal events
  logic rin_fall, pres_chg;
  logic chk_good, abort, fault_start, start;
  logic a_hit, b_hit, w_hit, clk_start_evt, tmr_clr, tmr_inc;

  card_act_evt u_evt (
    .clk(clk), .rst_n(rst_n), .rst_in(rst_in), .card_present(card_present),
    .rin_fall(rin_fall), .pres_chg(pres_chg)
  );

  card_act_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .cnt(cnt)
  );

  always_comb begin
    chk_good    = (state == ST_IO) || (state == ST_CLKW) ||
                  (state == ST_WIN) || (state == ST_ON);
    abort       = (state != ST_IDLE) && (state != ST_DOWN) &&
                  abort_req(sess_cmd_n, card_present, supply_good, chk_good);
    fault_start = abort && fault_req(card_present, supply_good, chk_good);
    start       = (state == ST_IDLE) && !sess_cmd_n && card_present;
    a_hit       = limit_hit(32'(cnt), IO2CLK_CYC);
    b_hit       = limit_hit(32'(cnt), CLK2RST_CYC);
    w_hit       = limit_hit(32'(cnt), WIN_CYC);
    clk_start_evt = (state == ST_IO) && !abort &&
                    (cbr_q ? (rin_fall || w_hit) : a_hit);
    tmr_clr     = (state == ST_IDLE) || (state == ST_RAMP) ||
                  (state == ST_IO && !cbr_q && a_hit) ||
                  (state == ST_CLKW && b_hit);
    tmr_inc     = !tmr_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sup_q  <= 1'b0;
      io_q   <= 1'b0;
      clk_q  <= 1'b0;
      rs_q   <= 1'b0;
      cbr_q  <= 1'b0;
      irq_q  <= 1'b0;
      step_q <= 2'd0;
    end else begin
      irq_q <= pres_chg | fault_start;
      if (abort) begin
        rs_q   <= 1'b0;
        state  <= ST_DOWN;
        step_q <= 2'd1;
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            sup_q <= 1'b1;
            cbr_q <= rst_in;
            state <= ST_RAMP;
          end
          ST_RAMP: if (supply_good) begin
            io_q  <= 1'b1;
            state <= ST_IO;
          end
          ST_IO: if (clk_start_evt) begin
            clk_q <= 1'b1;
            state <= cbr_q ? ST_WIN : ST_CLKW;
          end
          ST_CLKW: if (b_hit) begin
            rs_q  <= 1'b1;
            state <= ST_ON;
          end
          ST_WIN: if (w_hit) begin
            rs_q  <= 1'b1;
            state <= ST_ON;
          end
          ST_DOWN: begin
            step_q <= step_q + 2'd1;
            case (step_q)
              2'd1: clk_q <= 1'b0;
              2'd2: io_q  <= 1'b0;
              default: begin
                sup_q <= 1'b0;
                state <= ST_IDLE;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign supply_en = sup_q;
  assign io_en     = io_q;
  assign clk_en    = clk_q;
  assign card_rst  = rs_q & rst_in;
  assign irq       = irq_q;

  // ---------------- assertions ----------------
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !(supply_en || io_en || clk_en || card_rst));

  p_absent_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !card_present) |=> !supply_en);

  p_ramp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RAMP |-> !io_en && !clk_en && !card_rst);

  p_ramp_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RAMP && !supply_good && !abort) |=> state == ST_RAMP);

  p_chain_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en |-> io_en) and (io_en |-> supply_en) and (card_rst |-> clk_en));

  p_mode_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_DOWN) |=> $stable(cbr_q));

  p_fall_starts_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IO && cbr_q && rin_fall && !abort) |=> clk_en);

  p_window_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_q && (state == ST_IO || state == ST_WIN)) |-> !card_rst);

  p_supply_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> !io_en && !clk_en && !card_rst);

  p_io_after_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_en) |-> !clk_en && !card_rst);

  p_fault_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_start |=> irq);

endmodule

// File: tb/card_act_seq_tb.sv
module card_act_seq_tb;
  localparam int A = 4, B = 3, W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_present = 1'b0, sess_cmd_n = 1'b1, supply_good = 1'b0, rst_in = 1'b0;
  logic supply_en, io_en, clk_en, card_rst, irq;

  always #2 clk = ~clk;

  card_act_seq #(.IO2CLK_CYC(A), .CLK2RST_CYC(B), .WIN_CYC(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .card_present(card_present), .sess_cmd_n(sess_cmd_n),
    .supply_good(supply_good), .rst_in(rst_in), .supply_en(supply_en),
    .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .irq(irq)
  );

  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference: phase 0 idle,1 ramp,2 io,3 timed wait,4 window,5 on,6 down
  int m_ph = 0, m_cnt = 0, m_dstep = 0;
  bit m_sup, m_io, m_clk, m_rs, m_cbr, m_irq, m_rprev, m_pprev;

  task automatic go_down(input bit flt);
    m_rs = 0; m_ph = 6; m_dstep = 1;
    if (flt) m_irq = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_dstep = 0;
      {m_sup, m_io, m_clk, m_rs, m_cbr, m_irq, m_rprev, m_pprev} = '0;
    end else begin
      bit fall, base, full;
      fall  = m_rprev && !rst_in;
      base  = sess_cmd_n || !card_present;
      full  = base || !supply_good;
      m_irq = (card_present != m_pprev);
      if (m_ph == 1 && base) go_down(!card_present);
      else if (m_ph >= 2 && m_ph <= 5 && full) go_down(!card_present || !supply_good);
      else begin
        case (m_ph)
          0: if (!sess_cmd_n && card_present) begin m_ph = 1; m_sup = 1; m_cbr = rst_in; m_cnt = 0; end
          1: if (supply_good) begin m_io = 1; m_ph = 2; m_cnt = 0; end
          2: if (m_cbr) begin
               if (fall || m_cnt == W - 1) begin m_clk = 1; m_ph = 4; end
               m_cnt++;
             end else if (m_cnt == A - 1) begin m_clk = 1; m_ph = 3; m_cnt = 0; end
             else m_cnt++;
          3: if (m_cnt == B - 1) begin m_rs = 1; m_ph = 5; end else m_cnt++;
          4: if (m_cnt >= W - 1) begin m_rs = 1; m_ph = 5; end else m_cnt++;
          6: begin
               if (m_dstep == 1) m_clk = 0;
               else if (m_dstep == 2) m_io = 0;
               else begin m_sup = 0; m_ph = 0; end
               m_dstep++;
             end
          default: ;
        endcase
      end
      m_rprev = rst_in;
      m_pprev = card_present;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic cmp();
    logic [4:0] act, exp;
    act = {supply_en, io_en, clk_en, card_rst, irq};
    exp = {m_sup, m_io, m_clk, m_rs && rst_in, m_irq};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s model compare {sup,io,clk,rst,irq}: actual=%b expected=%b", cur_req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(supply_en | io_en | clk_en | card_rst | irq, 1'b0, "R1", "outputs after reset");

    // command with no card
    cur_req = "R2"; sess_cmd_n = 1'b0;
    step(6);
    chk(supply_en, 1'b0, "R2", "supply with no card");

    // insert card: start + presence pulse, timed mode (rst_in low)
    card_present = 1'b1;
    step(1);
    chk(irq, 1'b1, "R11", "irq on insertion");
    chk(supply_en, 1'b1, "R2", "supply after start");
    cur_req = "R3";
    step(5);
    chk(io_en, 1'b0, "R3", "io while supply not good");
    supply_good = 1'b1;
    step(1);
    chk(io_en, 1'b1, "R3", "io after supply good");
    cur_req = "R5"; rst_in = 1'b1;     // mode already latched as timed
    step(2);
    rst_in = 1'b0;
    step(1);
    chk(clk_en, 1'b0, "R4", "clock before delay");
    step(1);
    chk(clk_en, 1'b1, "R5", "timed clock start ignores rst_in changes");
    cur_req = "R4";
    step(2);
    chk(card_rst, 1'b0, "R4", "reset stage not yet open");
    rst_in = 1'b1;
    step(1);
    chk(card_rst, 1'b1, "R9", "card reset follows rst_in high");
    cur_req = "R9"; rst_in = 1'b0;
    step(1);
    chk(card_rst, 1'b0, "R9", "card reset follows rst_in low");
    rst_in = 1'b1;
    step(1);

    // host stop: reverse order, no irq
    cur_req = "R10"; sess_cmd_n = 1'b1;
    step(1);
    chk(card_rst, 1'b0, "R10", "reset drops first");
    chk(clk_en, 1'b1, "R10", "clock still on at step 1");
    chk(irq, 1'b0, "R11", "no irq on host stop");
    step(1);
    chk(clk_en, 1'b0, "R10", "clock drops second");
    chk(io_en, 1'b1, "R10", "io still on at step 2");
    step(1);
    chk(io_en, 1'b0, "R10", "io drops third");
    step(1);
    chk(supply_en, 1'b0, "R10", "supply drops last");
    step(2);

    // reset-gated mode with an early fall
    cur_req = "R6"; rst_in = 1'b1; sess_cmd_n = 1'b0;
    step(2);
    chk(io_en, 1'b1, "R6", "io on in gated session");
    step(5);
    chk(clk_en, 1'b0, "R6", "clock waits for rst_in fall");
    rst_in = 1'b0;
    step(1);
    chk(clk_en, 1'b1, "R6", "clock starts after fall");
    cur_req = "R7"; rst_in = 1'b1;
    step(3);
    chk(card_rst, 1'b0, "R7", "reset held inside window");
    step(11);
    chk(card_rst, 1'b1, "R7", "reset copies rst_in after window");
    rst_in = 1'b0;
    step(1);
    chk(card_rst, 1'b0, "R7", "reset copies rst_in low");
    chk(clk_en, 1'b1, "R7", "rst_in no longer gates clock");
    rst_in = 1'b1;
    step(2);

    // supply loss fault, then restart gated with no fall
    cur_req = "R11"; supply_good = 1'b0;
    step(1);
    chk(irq, 1'b1, "R11", "irq on supply loss");
    chk(card_rst, 1'b0, "R10", "reset drops on fault");
    step(4);
    cur_req = "R8";
    chk(supply_en, 1'b1, "R8", "restart while card and command stay");
    supply_good = 1'b1;
    step(1);
    chk(io_en, 1'b1, "R8", "io on in fallback session");
    step(19);
    chk(clk_en, 1'b0, "R8", "clock off before window end");
    step(1);
    chk(clk_en, 1'b1, "R8", "clock starts at window end");
    step(1);
    chk(card_rst, 1'b1, "R8", "reset stage opens after fallback clock");

    // card removal during ramp
    cur_req = "R10"; sess_cmd_n = 1'b1;
    step(5);
    supply_good = 1'b0; sess_cmd_n = 1'b0;
    step(2);
    chk(supply_en, 1'b1, "R3", "ramping without supply good");
    card_present = 1'b0;
    step(1);
    chk(irq, 1'b1, "R11", "irq on removal");
    step(2);
    chk(supply_en, 1'b1, "R10", "supply held until last step");
    step(1);
    chk(supply_en, 1'b0, "R10", "supply off after removal");
    step(4);
    chk(supply_en, 1'b0, "R2", "no restart without card");

    summary();
    $finish;
  end
endmodule